// File: doc/BRIEF.md
# Flash Program/Erase Control Sequencer

This block sits between a CPU register bus and a flash array. It holds a small control register with three mode bits and a high-voltage enable. It also watches the bus traffic around the flash. From that traffic it checks that an erase or program setup is done in the required order before the array's high voltage may be switched on. The CPU writes the control register and reads the block-protect register. It writes any byte into the target page and then waits out a setup window before it raises the high-voltage bit. The block latches the page address, drives the mode and high-voltage outputs toward the array, and times the erase.

Both time windows are given in microseconds and turned into clock cycles from a clock-rate parameter. If a step is taken out of order, the sequence falls back to the mode-set step and the high-voltage request is refused. The interrupt-vector page can be cleared only by a mass erase.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset all control bits, the latched page, the high-voltage output and both status pulses are 0.
- R2: The control register sits at CTRL_ADDR (default 0xFE08). Bit 3 is HV enable, bit 2 is mass select, bit 1 is erase and bit 0 is program. Bits 7..4 read 0 and ignore writes. rdata_o shows the register in the same cycle that rd_i addresses it, and is 0 otherwise.
- R3: Erase and program are never both 1. A write that sets both, or sets one while the other is already 1, leaves both bits unchanged.
- R4: A write of 1 to the HV bit is ignored unless program or erase is set and the setup sequence has completed.
- R5: The setup order is: set the mode (mass clear for page erase), read the protect register at PROT_ADDR (default 0xFE09), write to the target page, let NVS_CYC cycles pass, then write the HV bit. The HV write is accepted if it is captured at least NVS_CYC+1 edges after the page write was captured.
- R6: A step out of order returns the sequence to the mode-set step, and later HV writes are refused until the protect read, the page write and the wait are repeated. Clearing the mode returns the sequence to idle.
- R7: page_addr_o takes the written address with its low 6 bits zeroed, but only for writes inside the user area 0xDC00..0xFBFF (or the vector page where R8 allows it). Other writes leave it unchanged and do not advance the sequence.
- R8: A write to the vector page 0xFFDC..0xFFFF is refused as a page-erase target. It is accepted in mass-erase or program mode.
- R9: In erase mode, erase_done_o pulses for one cycle ERASE_CYC cycles after the edge that accepted the HV bit, provided the HV bit is still held.
- R10: Clearing the HV bit or the erase bit during an erase that has not finished drops hv_en_o at the capturing edge and pulses erase_aborted_o in that same cycle. Clearing after erase_done gives no abort pulse.
- R11: mass_o is the mass bit qualified by erase. erase_mode_o and prog_mode_o follow the erase and program bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Bus address |
| wdata_i | input | 8 | Bus write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data (combinational) |
| hv_en_o | output | 1 | High voltage to array |
| erase_mode_o | output | 1 | Erase mode selected |
| prog_mode_o | output | 1 | Program mode selected |
| mass_o | output | 1 | Mass erase selected |
| page_addr_o | output | ADDR_W | Latched page address |
| erase_done_o | output | 1 | Erase time elapsed, one-cycle pulse |
| erase_aborted_o | output | 1 | Erase aborted, one-cycle pulse |

## Verification
Register reads are due in the same cycle as the strobe. Control-bit changes, the high-voltage output, the latched page and the abort pulse are due in the cycle that starts at the edge capturing the write. erase_done_o is due exactly ERASE_CYC cycles after the accepting edge. The driver records the cycle number each result is due in, and the monitor compares only in that cycle, sampling shortly after the falling edge. The done pulse is also checked to be low one cycle before and one cycle after. The setup window is probed one cycle short, which must be refused, and at its exact minimum, which must be accepted.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_MODE_SET, ST_PROT_READ, ST_ADDR_LATCHED,
    ST_NVS_WAIT, ST_HV_READY, ST_ERASING
  } seq_state_e;

  typedef struct packed {
    logic hven;
    logic mass;
    logic erase;
    logic pgm;
  } ctrl_bits_t;

  localparam int CTRL_W = 4;
  localparam int PAGE_LSB = 6;
endpackage

// File: rtl/fseq_bus_decode.sv
module fseq_bus_decode #(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hFE08,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 'hFE09,
  parameter logic [ADDR_W-1:0] USER_LO   = 'hDC00,
  parameter logic [ADDR_W-1:0] USER_HI   = 'hFBFF,
  parameter logic [ADDR_W-1:0] VEC_LO    = 'hFFDC,
  parameter logic [ADDR_W-1:0] VEC_HI    = 'hFFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              page_erase_i,
  output logic              ctrl_wr_o,
  output logic              ctrl_rd_o,
  output logic              prot_rd_o,
  output logic              flash_ok_o
);
  logic in_user, in_vec;

  assign in_user    = (addr_i >= USER_LO) && (addr_i <= USER_HI);
  assign in_vec     = (addr_i >= VEC_LO) && (addr_i <= VEC_HI);
  assign ctrl_wr_o  = wr_i && (addr_i == CTRL_ADDR);
  assign ctrl_rd_o  = rd_i && (addr_i == CTRL_ADDR);
  assign prot_rd_o  = rd_i && (addr_i == PROT_ADDR);
  // vector page is never a page-erase target
  assign flash_ok_o = wr_i && (in_user || (in_vec && !page_erase_i));
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fseq_ctrl_reg.sv
module fseq_ctrl_reg
  import flash_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              hv_ready_i,
  output ctrl_bits_t        q_o,
  output ctrl_bits_t        nx_o,
  output logic              hv_attempt_o,
  output logic              mass_chg_o
);
  ctrl_bits_t q_q, d, nx;
  logic blocked;

  always_comb begin
    d       = ctrl_bits_t'(wdata_i);
    nx      = q_q;
    blocked = (d.pgm && d.erase) || (d.pgm && q_q.erase) || (d.erase && q_q.pgm);
    if (wr_i) begin
      nx.pgm   = blocked ? q_q.pgm   : d.pgm;
      nx.erase = blocked ? q_q.erase : d.erase;
      nx.mass  = d.mass;
      nx.hven  = d.hven && (nx.pgm || nx.erase) && (nx.mass == q_q.mass)
                 && (q_q.hven || hv_ready_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= nx;
  end

  assign q_o          = q_q;
  assign nx_o         = nx;
  assign hv_attempt_o = wr_i && d.hven && !q_q.hven;
  assign mass_chg_o   = wr_i && (d.mass != q_q.mass);

  AST_MODES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(q_q.erase && q_q.pgm)); // R3
  AST_HV_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q.hven |-> (q_q.erase || q_q.pgm)); // R4
  AST_HV_RISE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_q.hven) |-> $past(hv_ready_i)); // R5
endmodule

// File: rtl/fseq_fsm.sv
module fseq_fsm
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 8,
  parameter int NVS_CYC  = 10,
  parameter int ERASE_CYC = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  ctrl_bits_t        q_i,
  input  ctrl_bits_t        nx_i,
  input  logic              ctrl_wr_i,
  input  logic              hv_attempt_i,
  input  logic              mass_chg_i,
  input  logic              prot_rd_i,
  input  logic              flash_ok_i,
  input  logic              zero_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_val_o,
  output logic              hv_ready_o,
  output logic [ADDR_W-1:0] page_addr_o,
  output logic              done_o,
  output logic              aborted_o
);
  localparam logic [CNT_W-1:0] NVS_LD   = CNT_W'(NVS_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);

  seq_state_e state_q, state_d;
  logic [ADDR_W-1:0] page_q;
  logic done_flag_q, done_q, abort_q;
  logic mode_nx, step_evt, latch, done_hit, abort_hit;

  assign mode_nx    = nx_i.erase || nx_i.pgm;
  assign step_evt   = prot_rd_i || flash_ok_i || hv_attempt_i || mass_chg_i;
  assign hv_ready_o = (state_q == ST_HV_READY) || (state_q == ST_NVS_WAIT && zero_i);
  assign latch      = (state_q == ST_PROT_READ) && flash_ok_i && mode_nx;
  assign done_hit   = (state_q == ST_ERASING) && zero_i && q_i.hven && nx_i.hven
                      && q_i.erase && !done_flag_q;
  assign abort_hit  = (state_q == ST_ERASING) && q_i.erase && !done_flag_q
                      && ctrl_wr_i && !nx_i.hven;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = NVS_LD;
    if (!mode_nx) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:     state_d = ST_MODE_SET;
        ST_MODE_SET: if (prot_rd_i) state_d = ST_PROT_READ;
        ST_PROT_READ: begin
          if (hv_attempt_i || mass_chg_i) state_d = ST_MODE_SET;
          else if (flash_ok_i)            state_d = ST_ADDR_LATCHED;
        end
        ST_ADDR_LATCHED: begin
          if (step_evt) state_d = ST_MODE_SET;
          else begin
            state_d    = ST_NVS_WAIT;
            tmr_load_o = 1'b1;
          end
        end
        ST_NVS_WAIT: begin
          if (zero_i && nx_i.hven) begin
            state_d    = ST_ERASING;
            tmr_load_o = 1'b1;
            tmr_val_o  = ERASE_LD;
          end else if (step_evt) state_d = ST_MODE_SET;
          else if (zero_i)       state_d = ST_HV_READY;
        end
        ST_HV_READY: begin
          if (nx_i.hven) begin
            state_d    = ST_ERASING;
            tmr_load_o = 1'b1;
            tmr_val_o  = ERASE_LD;
          end else if (step_evt) state_d = ST_MODE_SET;
        end
        ST_ERASING: if (!nx_i.hven) state_d = ST_MODE_SET;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      page_q      <= '0;
      done_flag_q <= 1'b0;
      done_q      <= 1'b0;
      abort_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (latch) page_q <= {addr_i[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
      done_q  <= done_hit;
      abort_q <= abort_hit;
      if (state_d != ST_ERASING) done_flag_q <= 1'b0;
      else if (done_hit)         done_flag_q <= 1'b1;
    end
  end

  assign page_addr_o = page_q;
  assign done_o      = done_q;
  assign aborted_o   = abort_q;

  AST_DONE_NEEDS_HV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(q_i.hven)); // R9
  AST_ABORT_HV_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> !q_i.hven); // R10
  AST_PAGE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(page_q) |-> $past(flash_ok_i)); // R7
  AST_DONE_XOR_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && abort_q)); // R10
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hFE08,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 'hFE09,
  parameter logic [ADDR_W-1:0] USER_LO   = 'hDC00,
  parameter logic [ADDR_W-1:0] USER_HI   = 'hFBFF,
  parameter logic [ADDR_W-1:0] VEC_LO    = 'hFFDC,
  parameter logic [ADDR_W-1:0] VEC_HI    = 'hFFFF,
  parameter int               CLK_KHZ   = 200000,
  parameter int               NVS_US    = 10,
  parameter int               ERASE_US  = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic              hv_en_o,
  output logic              erase_mode_o,
  output logic              prog_mode_o,
  output logic              mass_o,
  output logic [ADDR_W-1:0] page_addr_o,
  output logic              erase_done_o,
  output logic              erase_aborted_o
);
  localparam int NVS_RAW   = (CLK_KHZ * NVS_US) / 1000;
  localparam int ERASE_RAW = (CLK_KHZ * ERASE_US) / 1000;
  localparam int NVS_CYC   = (NVS_RAW < 1) ? 1 : NVS_RAW;
  localparam int ERASE_CYC = (ERASE_RAW < 1) ? 1 : ERASE_RAW;
  localparam int CNT_W     = $clog2(ERASE_CYC + 1);

  ctrl_bits_t ctrl_q, ctrl_nx;
  logic ctrl_wr, ctrl_rd, prot_rd, flash_ok;
  logic hv_attempt, mass_chg, hv_ready, tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[7:CTRL_W];

  fseq_bus_decode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .PROT_ADDR(PROT_ADDR),
    .USER_LO(USER_LO), .USER_HI(USER_HI), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)
  ) i_decode (
    .addr_i       (addr_i),
    .wr_i         (wr_i),
    .rd_i         (rd_i),
    .page_erase_i (ctrl_q.erase && !ctrl_q.mass),
    .ctrl_wr_o    (ctrl_wr),
    .ctrl_rd_o    (ctrl_rd),
    .prot_rd_o    (prot_rd),
    .flash_ok_o   (flash_ok)
  );

  fseq_ctrl_reg i_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (ctrl_wr),
    .wdata_i      (wdata_i[CTRL_W-1:0]),
    .hv_ready_i   (hv_ready),
    .q_o          (ctrl_q),
    .nx_o         (ctrl_nx),
    .hv_attempt_o (hv_attempt),
    .mass_chg_o   (mass_chg)
  );

  fseq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  fseq_fsm #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NVS_CYC(NVS_CYC), .ERASE_CYC(ERASE_CYC)
  ) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .q_i          (ctrl_q),
    .nx_i         (ctrl_nx),
    .ctrl_wr_i    (ctrl_wr),
    .hv_attempt_i (hv_attempt),
    .mass_chg_i   (mass_chg),
    .prot_rd_i    (prot_rd),
    .flash_ok_i   (flash_ok),
    .zero_i       (tmr_zero),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .hv_ready_o   (hv_ready),
    .page_addr_o  (page_addr_o),
    .done_o       (erase_done_o),
    .aborted_o    (erase_aborted_o)
  );

  assign rdata_o      = ctrl_rd ? {{(8-CTRL_W){1'b0}}, ctrl_q} : 8'h00;
  assign hv_en_o      = ctrl_q.hven;
  assign erase_mode_o = ctrl_q.erase;
  assign prog_mode_o  = ctrl_q.pgm;
  assign mass_o       = ctrl_q.mass && ctrl_q.erase;

  AST_HV_OUT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> (erase_mode_o ^ prog_mode_o)); // R4
endmodule

// File: tb/test_flash_seq_ctrl.sv
`timescale 1ns/1ps
module test_flash_seq_ctrl;
  localparam int NVS   = 10;
  localparam int ERASE = 4000;
  localparam logic [15:0] CA = 16'hFE08;
  localparam logic [15:0] PA = 16'hFE09;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic hv, emode, pmode, mass, done, abrt;
  logic [15:0] page;

  always #2.5 clk = ~clk;

  flash_seq_ctrl #(.CLK_KHZ(1000), .NVS_US(10), .ERASE_US(4000)) i_flash_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .hv_en_o(hv), .erase_mode_o(emode), .prog_mode_o(pmode),
    .mass_o(mass), .page_addr_o(page), .erase_done_o(done), .erase_aborted_o(abrt)
  );

  typedef enum int {S_RDATA, S_HV, S_PAGE, S_DONE, S_ABORT, S_MASS, S_EMODE, S_PMODE} sel_e;
  typedef struct { int due; sel_e sel; logic [15:0] exp; string tag; } item_t;
  item_t sb[$];
  int cyc = 0, checks = 0, errors = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] observe(sel_e s);
    case (s)
      S_RDATA: return {8'h00, rdata};
      S_HV:    return {15'd0, hv};
      S_PAGE:  return page;
      S_DONE:  return {15'd0, done};
      S_ABORT: return {15'd0, abrt};
      S_MASS:  return {15'd0, mass};
      S_EMODE: return {15'd0, emode};
      default: return {15'd0, pmode};
    endcase
  endfunction

  // monitor: compare every item due in the current cycle
  always @(negedge clk) begin
    #1;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [15:0] act;
        act = observe(sb[i].sel);
        checks++;
        if (act !== sb[i].exp) begin
          errors++;
          $display("FAIL %s: %s got %h expected %h (cycle %0d)",
                   sb[i].tag, sb[i].sel.name(), act, sb[i].exp, cyc);
        end
        sb.delete(i);
      end
    end
  end

  task automatic push(int delta, sel_e s, logic [15:0] e, string tag);
    item_t it;
    it.due = cyc + delta; it.sel = s; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a, logic [7:0] e, string tag);
    addr = a; rd = 1'b1;
    push(0, S_RDATA, {8'h00, e}, tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic prot_rd();
    addr = PA; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [15:0] pg;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    push(0, S_HV, 0, "R1"); push(0, S_PAGE, 0, "R1");
    push(0, S_DONE, 0, "R1"); push(0, S_ABORT, 0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    bus_rd(CA, 8'h00, "R1");

    // R2: upper bits ignored, other address reads 0
    bus_wr(CA, 8'hF0);
    bus_rd(CA, 8'h00, "R2");
    bus_wr(CA, 8'h01);
    bus_rd(16'hFE07, 8'h00, "R2");

    // R3: interlock
    bus_wr(CA, 8'h02);             // erase while pgm set: blocked
    bus_rd(CA, 8'h01, "R3");
    bus_wr(CA, 8'h00);
    bus_wr(CA, 8'h03);             // both at once: blocked
    bus_rd(CA, 8'h00, "R3");
    bus_wr(CA, 8'h02);
    bus_wr(CA, 8'h01);             // pgm while erase set: blocked
    bus_rd(CA, 8'h02, "R3");
    push(0, S_EMODE, 1, "R11"); push(0, S_MASS, 0, "R11");

    // R4: HV without sequence ignored
    bus_wr(CA, 8'h0A);
    push(0, S_HV, 0, "R4");
    bus_rd(CA, 8'h02, "R4");

    // R6/R7: page write before protect read is not latched
    bus_wr(16'hE047, 8'h55);
    push(0, S_PAGE, 0, "R6");
    idle(NVS);
    bus_wr(CA, 8'h0A);
    push(0, S_HV, 0, "R6");

    // R8/R7: in sequence, vector page and outside area refused
    prot_rd();
    bus_wr(16'hFFF0, 8'h00);
    push(0, S_PAGE, 0, "R8");
    bus_wr(16'h8000, 8'h00);
    push(0, S_PAGE, 0, "R7");
    bus_wr(16'hDC3F, 8'h00);
    push(0, S_PAGE, 16'hDC00, "R7");
    // R5: one cycle early refused, sequence falls back
    idle(NVS - 1);
    bus_wr(CA, 8'h0A);
    push(0, S_HV, 0, "R5");
    idle(NVS);
    bus_wr(CA, 8'h0A);
    push(0, S_HV, 0, "R6");

    // R5/R9: full page erase with exact minimum wait
    prot_rd();
    bus_wr(16'hE047, 8'hAA);
    push(0, S_PAGE, 16'hE040, "R7");
    idle(NVS);
    bus_wr(CA, 8'h0A);
    push(0, S_HV, 1, "R5");
    push(ERASE - 1, S_DONE, 0, "R9");
    push(ERASE, S_DONE, 1, "R9");
    push(ERASE + 1, S_DONE, 0, "R9");
    idle(ERASE + 2);
    bus_wr(CA, 8'h02);             // clear HV after done: no abort
    push(0, S_HV, 0, "R10"); push(0, S_ABORT, 0, "R10");

    // R10: abort by clearing HV
    prot_rd();
    bus_wr(16'hF0C1, 8'h00);
    push(0, S_PAGE, 16'hF0C0, "R7");
    idle(NVS);
    bus_wr(CA, 8'h0A);
    push(0, S_HV, 1, "R5");
    push(ERASE, S_DONE, 0, "R10");
    idle(7);
    bus_wr(CA, 8'h02);
    push(0, S_HV, 0, "R10"); push(0, S_ABORT, 1, "R10");
    push(1, S_ABORT, 0, "R10");
    idle(ERASE);

    // R8/R10/R11: mass erase accepts vector page, abort by clearing erase
    bus_wr(CA, 8'h06);
    push(0, S_MASS, 1, "R11");
    prot_rd();
    bus_wr(16'hFFE5, 8'h00);
    push(0, S_PAGE, 16'hFFC0, "R8");
    idle(NVS);
    bus_wr(CA, 8'h0E);
    push(0, S_HV, 1, "R5");
    idle(3);
    bus_wr(CA, 8'h00);
    push(0, S_HV, 0, "R10"); push(0, S_ABORT, 1, "R10");
    push(0, S_MASS, 0, "R11");
    bus_rd(CA, 8'h00, "R10");

    // R4/R11: program mode follows the same setup
    bus_wr(CA, 8'h01);
    push(0, S_PMODE, 1, "R11"); push(0, S_EMODE, 0, "R11");
    bus_wr(CA, 8'h09);
    push(0, S_HV, 0, "R4");
    prot_rd();
    pg = 16'hFB80;
    bus_wr(16'hFBBF, 8'h00);
    push(0, S_PAGE, pg, "R7");
    idle(NVS);
    bus_wr(CA, 8'h09);
    push(0, S_HV, 1, "R4");
    bus_rd(CA, 8'h09, "R2");
    bus_wr(CA, 8'h00);
    push(0, S_HV, 0, "R6"); push(0, S_ABORT, 0, "R10");

    idle(3);
    finished = 1;
    if (sb.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule